// File: doc/BRIEF.md
# Dual-Clock FIFO With Retransmit

This block is a first-in first-out buffer for 9-bit words that sit between two unrelated clock domains. Words go into on-chip storage on write-clock edges and come out on read-clock edges. The depth is a parameter and must be a power of two, at least 4. Each side keeps a binary pointer and a Gray-coded pointer. Each Gray pointer crosses to the other domain through a two-flop synchronizer. The full status is worked out on the write side and the empty status on the read side.

The block has two flag conventions. The level of `fwft_sel_i` is sampled while the master reset is held, and that choice stays in force until the next master reset.

- **Standard mode:** a read request loads the next word into the output register. The two status pins report full and empty.
- **Fall-through mode:** a one-word output stage fetches the head word by itself. A read request consumes the word in the stage. The status pins report room to write and valid data on the output.

A partial reset empties the buffer but keeps the mode. A retransmit pulse rewinds only the read pointer, so the words already written can be read again from the first one.

Top module: `dcf_rt_fifo`

## Requirements
- R1: While `rst_ni` is low, `rdata_o` is 0 and the level of `fwft_sel_i` is taken as the mode (1 = fall-through, 0 = standard). After release the buffer is empty. In standard mode this gives `wstat_o`=0, `rstat_o`=1 and `half_o`=0. In fall-through mode it gives `wstat_o`=1 and `rstat_o`=0.
- R2: Pulling `prst_ni` low clears `rdata_o` at once, without a clock edge, and empties the buffer. It leaves the mode untouched, whatever `fwft_sel_i` does meanwhile.
- R3: A word is stored on a rising `wclk_i` edge only when `wr_en_i` is 1 and the buffer is not full. A write while full is dropped.
- R4: In standard mode, a rising `rclk_i` edge with `rd_en_i`=1 and the buffer not empty puts the oldest unread word on `rdata_o` after that edge. A read while empty leaves `rdata_o` unchanged.
- R5: In standard mode, `wstat_o`=1 exactly when DEPTH words are stored, and `rstat_o`=1 exactly when none are stored. Each flag sees the other side's activity after a synchronizer delay.
- R6: In fall-through mode, the oldest word appears on `rdata_o` with `rstat_o`=1 without any read request. It holds there until a read-clock edge with `rd_en_i`=1 consumes it. The next word then replaces it, or `rstat_o` drops to 0 if the buffer is empty.
- R7: In fall-through mode, `wstat_o`=1 while there is room for another word in storage. It is 0 once DEPTH words wait behind the output stage.
- R8: `rt_i`=1 on a rising `rclk_i` edge sets the read pointer back to the first word written since the last reset, and the write pointer is left alone. If `rd_en_i` is high on the same edge, the retransmit takes priority and no word is read. Retransmit is only meaningful while at most DEPTH words have been written since reset.
- R9: After a retransmit edge, for one read cycle, `rstat_o` is 1 in standard mode (empty) and 0 in fall-through mode (no valid data). After that the first word is available again.
- R10: `half_o`=1 when more than DEPTH/2 words are in storage and 0 otherwise. It is updated in the write domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous assert |
| prst_ni | input | 1 | Partial reset, active low, keeps the mode |
| fwft_sel_i | input | 1 | Mode select, sampled during master reset |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 9 | Write data |
| rd_en_i | input | 1 | Read request or consume |
| rt_i | input | 1 | Retransmit: rewind the read pointer |
| rdata_o | output | 9 | Output data register |
| wstat_o | output | 1 | Full (standard mode) or room to write (fall-through mode) |
| rstat_o | output | 1 | Empty (standard mode) or output valid (fall-through mode) |
| half_o | output | 1 | More than half the capacity in use |

## Verification
A retransmit and a read request can land on the same read-clock edge. The bench provokes this by raising `rt_i` and `rd_en_i` together after two words have been read in standard mode. It then checks three things: `rdata_o` still holds the previous word, the empty flag shows for one cycle, and the next read returns the first word written. A full pass over all stored words after the final rewind ends on empty, which shows that the write pointer did not move.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] q;
  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni) q <= 2'b00;
    else          q <= {q[0], 1'b1};
  assign rst_no = q[1];
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  assign q_o = s2_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fwft_i,
  input  logic        wr_en_i,
  input  logic [AW:0] rgray_s_i,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        wfire_o,
  output logic        full_o,
  output logic        wstat_o,
  output logic        half_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, wgray_nx, rbin_s, cnt_nx;
  logic          full_q, half_q;

  always_comb begin
    wfire_o  = wr_en_i && !full_q;
    wbin_nx  = wbin_q + PW'(wfire_o);
    wgray_nx = PW'(fifo_pkg::bin2gray(32'(wbin_nx)));
    rbin_s   = PW'(fifo_pkg::gray2bin(32'(rgray_s_i)));
    cnt_nx   = wbin_nx - rbin_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      // full: pointers differ only in the two top Gray bits
      full_q  <= (wgray_nx == {~rgray_s_i[PW-1:PW-2], rgray_s_i[PW-3:0]});
      half_q  <= (cnt_nx > PW'(HALF));
    end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign full_o  = full_q;
  assign wstat_o = fwft_i ? !full_q : full_q;
  assign half_o  = half_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic          rt_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          rstat_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, rgray_nx;
  logic [DW-1:0] dout_q;
  logic          empty_q, empty_nx, ov_q, fire;

  always_comb begin
    // fall-through: fetch whenever the stage is free or being consumed
    fire     = !empty_q && !rt_i && (fwft_i ? (!ov_q || rd_en_i) : rd_en_i);
    rbin_nx  = rt_i ? '0 : rbin_q + PW'(fire);
    rgray_nx = PW'(fifo_pkg::bin2gray(32'(rbin_nx)));
    empty_nx = rt_i || (rgray_nx == wgray_s_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rgray_nx;
      empty_q <= empty_nx;
      if (fire) dout_q <= mem_rdata_i;
      if (rt_i)         ov_q <= 1'b0;
      else if (fire)    ov_q <= 1'b1;
      else if (rd_en_i) ov_q <= 1'b0;
    end

  assign raddr_o = rbin_q[AW-1:0];
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign rdata_o = dout_q;
  assign empty_o = empty_q;
  assign rstat_o = fwft_i ? ov_q : empty_q;
endmodule

// File: rtl/dcf_rt_fifo.sv
module dcf_rt_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 9
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic          rt_i,
  output logic [DW-1:0] rdata_o,
  output logic          wstat_o,
  output logic          rstat_o,
  output logic          half_o
);
  import fifo_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          arst_n, wrst_n, rrst_n;
  fifo_mode_e    mode_w_q, mode_r_q;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [AW-1:0] raddr;
  logic          wfire, full, empty;
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_rdata;

  assign arst_n = rst_ni & prst_ni;

  dcf_rst_sync u_wrst (.clk_i(wclk_i), .arst_ni(arst_n), .rst_no(wrst_n));
  dcf_rst_sync u_rrst (.clk_i(rclk_i), .arst_ni(arst_n), .rst_no(rrst_n));

  // mode taken only while master reset is held; partial reset leaves it
  always_ff @(posedge wclk_i) if (!rst_ni) mode_w_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
  always_ff @(posedge rclk_i) if (!rst_ni) mode_r_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;

  dcf_gray_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_s));
  dcf_gray_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_s));

  dcf_wr_ctl #(.AW(AW)) u_wctl (
    .clk_i(wclk_i), .rst_ni(wrst_n), .fwft_i(mode_w_q == MODE_FWFT),
    .wr_en_i(wr_en_i), .rgray_s_i(rgray_s), .wbin_o(wbin), .wgray_o(wgray),
    .wfire_o(wfire), .full_o(full), .wstat_o(wstat_o), .half_o(half_o)
  );

  always_ff @(posedge wclk_i)
    if (wfire) mem_q[wbin[AW-1:0]] <= wdata_i;

  assign mem_rdata = mem_q[raddr];

  dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rctl (
    .clk_i(rclk_i), .rst_ni(rrst_n), .fwft_i(mode_r_q == MODE_FWFT),
    .rd_en_i(rd_en_i), .rt_i(rt_i), .wgray_s_i(wgray_s), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rbin_o(rbin), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_o(empty), .rstat_o(rstat_o)
  );
endmodule

// File: rtl/dcf_rt_fifo_chk.sv
module dcf_rt_fifo_chk #(
  parameter int PW = 5,
  parameter int DW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          fwft_r,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          rt_i,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rbin,
  input logic [DW-1:0] rdata_o,
  input logic          rstat_o
);
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    full && wr_en_i |=> $stable(wbin));

  p_gray_step_r3: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray)));

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    !fwft_r && empty && rd_en_i && !rt_i |=> $stable(rbin) && $stable(rdata_o));

  p_std_hold_r4: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    !fwft_r && !rd_en_i && !rt_i |=> $stable(rdata_o));

  p_fwft_hold_r6: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    fwft_r && rstat_o && !rd_en_i && !rt_i |=> rstat_o && $stable(rdata_o));

  p_rt_rewind_r8: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rt_i |=> rbin == '0);

  p_rt_flag_r9: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rt_i |=> rstat_o == !fwft_r);
endmodule

bind dcf_rt_fifo dcf_rt_fifo_chk #(.PW(PW), .DW(DW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .fwft_r(mode_r_q == fifo_pkg::MODE_FWFT), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rt_i(rt_i), .full(full), .empty(empty), .wbin(wbin), .wgray(wgray),
  .rbin(rbin), .rdata_o(rdata_o), .rstat_o(rstat_o)
);

// File: tb/dcf_rt_fifo_tb_top.sv
module dcf_rt_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 9;

  logic          wclk_i = 1'b0, rclk_i = 1'b0;
  logic          rst_ni, prst_ni, fwft_sel_i, wr_en_i, rd_en_i, rt_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic          wstat_o, rstat_o, half_o;
  int            vecs = 0, miss = 0;
  bit            done = 1'b0;

  always #5 wclk_i = ~wclk_i;
  always #7 rclk_i = ~rclk_i;

  dcf_rt_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(int base, int i);
    return DW'((base + i * 37) & 'h1FF);
  endfunction

  task automatic wr(logic [DW-1:0] v);
    @(negedge wclk_i); wr_en_i = 1'b1; wdata_i = v;
    @(negedge wclk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk_i); rd_en_i = 1'b1;
    @(negedge rclk_i); rd_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk_i);
    repeat (6) @(negedge rclk_i);
  endtask

  task automatic mreset(logic f);
    rst_ni = 1'b0; prst_ni = 1'b1; fwft_sel_i = f;
    wr_en_i = 1'b0; rd_en_i = 1'b0; rt_i = 1'b0; wdata_i = '0;
    repeat (4) @(negedge wclk_i);
    repeat (4) @(negedge rclk_i);
    chk("R1 rdata in reset", rdata_o, '0);
    rst_ni = 1'b1;
    fwft_sel_i = ~f;
    settle();
  endtask

  task automatic t_std_reset();
    mreset(1'b0);
    chk("R1 rdata", rdata_o, '0);
    chk("R1 wstat", DW'(wstat_o), '0);
    chk("R1 rstat", DW'(rstat_o), 9'd1);
    chk("R1 half", DW'(half_o), '0);
  endtask

  task automatic t_std_fill();
    for (int i = 0; i < 8; i++) wr(val(3, i));
    settle();
    chk("R10 half at DEPTH/2", DW'(half_o), '0);
    chk("R5 not empty", DW'(rstat_o), '0);
    wr(val(3, 8));
    settle();
    chk("R10 half above DEPTH/2", DW'(half_o), 9'd1);
    for (int i = 9; i < DEPTH; i++) wr(val(3, i));
    settle();
    chk("R5 full", DW'(wstat_o), 9'd1);
    wr(9'h0AA);
    settle();
    chk("R3 still full", DW'(wstat_o), 9'd1);
  endtask

  task automatic t_std_drain();
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R4 read order", rdata_o, val(3, i));
    end
    chk("R5 empty after drain (R3 extra dropped)", DW'(rstat_o), 9'd1);
    rd();
    chk("R4 read while empty holds data", rdata_o, val(3, DEPTH - 1));
    settle();
    chk("R5 full cleared", DW'(wstat_o), '0);
    chk("R10 half cleared", DW'(half_o), '0);
  endtask

  task automatic t_std_rt();
    @(negedge rclk_i); rt_i = 1'b1;
    @(negedge rclk_i); rt_i = 1'b0;
    chk("R9 std empty forced", DW'(rstat_o), 9'd1);
    @(negedge rclk_i);
    chk("R9 std data back", DW'(rstat_o), '0);
    rd(); chk("R8 first word again", rdata_o, val(3, 0));
    rd(); chk("R8 second word", rdata_o, val(3, 1));
    // retransmit and read on the same edge: retransmit wins
    @(negedge rclk_i); rt_i = 1'b1; rd_en_i = 1'b1;
    @(negedge rclk_i); rt_i = 1'b0; rd_en_i = 1'b0;
    chk("R8 rt beats read, data held", rdata_o, val(3, 1));
    chk("R9 rt with read empty forced", DW'(rstat_o), 9'd1);
    @(negedge rclk_i);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R8 replay order", rdata_o, val(3, i));
    end
    chk("R8 write pointer untouched", DW'(rstat_o), 9'd1);
  endtask

  task automatic t_fwft();
    mreset(1'b1);
    chk("R1 fwft rstat", DW'(rstat_o), '0);
    chk("R1 fwft wstat", DW'(wstat_o), 9'd1);
    for (int i = 0; i < 3; i++) wr(val(50, i));
    settle();
    chk("R6 head shown", rdata_o, val(50, 0));
    chk("R6 valid", DW'(rstat_o), 9'd1);
    rd();
    chk("R6 advance", rdata_o, val(50, 1));
    @(negedge rclk_i); rt_i = 1'b1;
    @(negedge rclk_i); rt_i = 1'b0;
    chk("R9 fwft valid dropped", DW'(rstat_o), '0);
    settle();
    chk("R8 fwft head again", rdata_o, val(50, 0));
    chk("R9 fwft valid back", DW'(rstat_o), 9'd1);
    rd(); chk("R6 next", rdata_o, val(50, 1));
    rd(); chk("R6 next", rdata_o, val(50, 2));
    rd(); chk("R6 drained", DW'(rstat_o), '0);
    for (int i = 0; i < DEPTH; i++) wr(val(90, i));
    settle();
    chk("R7 room with stage filled", DW'(wstat_o), 9'd1);
    wr(val(90, DEPTH));
    settle();
    chk("R7 no room", DW'(wstat_o), '0);
    wr(9'h155);
    settle();
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R3 fwft order", rdata_o, val(90, i));
      rd();
    end
    chk("R3 dropped write absent", DW'(rstat_o), '0);
  endtask

  task automatic t_partial();
    wr(val(200, 0)); wr(val(200, 1));
    settle();
    chk("R2 data before", rdata_o, val(200, 0));
    fwft_sel_i = 1'b0;
    #3 prst_ni = 1'b0;
    #1 chk("R2 async clear", rdata_o, '0);
    repeat (4) @(negedge rclk_i);
    prst_ni = 1'b1;
    settle();
    chk("R2 mode kept rstat", DW'(rstat_o), '0);
    chk("R2 mode kept wstat", DW'(wstat_o), 9'd1);
    wr(val(200, 5));
    settle();
    chk("R2 pointers cleared", rdata_o, val(200, 5));
    chk("R2 fall-through still", DW'(rstat_o), 9'd1);
  endtask

  initial begin
    rst_ni = 1'b0; prst_ni = 1'b1; fwft_sel_i = 1'b0;
    wr_en_i = 1'b0; rd_en_i = 1'b0; rt_i = 1'b0; wdata_i = '0;
    t_std_reset();
    t_std_fill();
    t_std_drain();
    t_std_rt();
    t_fwft();
    t_partial();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk_i);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule